// File: doc/BRIEF.md
# Product-Term Steering Array

This block sits between a product-term AND plane and a row of macrocells. It receives 160 product terms as 32 clusters of five. Each cluster is first reduced to a single OR. A per-cluster steering entry then sends that OR to one macrocell output within three positions of the cluster's own index. An output is the OR of every cluster steered to it, so the widest function it can build spans seven clusters, or 35 terms.

Any output can instead be switched to bypass. In bypass it carries only the OR of its own cluster and ignores anything steered to it. Five further product terms are not part of the steering. They leave the block unchanged as the shared control terms for the macrocells: set, reset, clock, clock enable and output enable.

The steering entries live in a small register bank. It is written one entry at a time through an address, a data word and a write strobe. The product-term path from inputs to outputs is purely combinational. Only the configuration is clocked.

Top module: `psteer_top`

## Requirements
- R1: Cluster j is the five input terms `pterm_i[5j+4:5j]`, and what it contributes is the OR of those five terms.
- R2: When `cfg_we_i` is high at a rising edge, the entry selected by `cfg_addr_i` takes `cfg_wdata_i` and routing follows it from that edge on. `cfg_wdata_i[2:0]` is a two's-complement offset and `cfg_wdata_i[3]` is the bypass bit.
- R3: After reset every entry holds offset 0 with bypass clear, so each output equals the OR of its own cluster.
- R4: A cluster j whose bypass bit is clear and whose offset o lies in -3..+3 contributes to output j+o when that index lies in 0..31. When it lies outside, the cluster contributes to no output.
- R5: The offset code 3'b100 (-4) is illegal, and a cluster holding it contributes to no output.
- R6: A non-bypassed output is the OR of all non-bypassed clusters steered to it. Seven clusters (35 terms) can merge into one output, and an output with no contributor is 0.
- R7: When entry k has bypass set, output k equals the OR of cluster k alone and ignores clusters steered to k. Cluster k then feeds no other output.
- R8: A cluster reaches at most one output, so the number of high outputs never exceeds the number of non-zero clusters.
- R9: `ctrl_o` follows `ctrl_term_i` bit for bit whatever the configuration.
- R10: While `cfg_we_i` is low, address and data changes leave every entry unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Configuration clock |
| rst_n | input | 1 | Asynchronous active-low reset of the entries |
| cfg_we_i | input | 1 | Entry write strobe |
| cfg_addr_i | input | 5 | Entry (cluster) index to write |
| cfg_wdata_i | input | 4 | Bit 3 bypass, bits 2:0 signed offset |
| pterm_i | input | 160 | Product terms, five per cluster |
| ctrl_term_i | input | 5 | Shared control product terms |
| mc_data_o | output | 32 | One data output per macrocell |
| ctrl_o | output | 5 | Control terms passed to the macrocells |

## Verification
The bench builds the block with its default values: 32 clusters of five terms, five control terms and a reach of three. With these values both array edges can be hit, where offsets fall off the ends. They also allow a full seven-cluster merge into one output with all 35 terms active and the illegal -4 offset code. A reach of three is also the largest span the 3-bit offset encodes, so every legal code gets exercised by the randomized configurations.

// File: rtl/psteer_pkg.sv
package psteer_pkg;

    // Signed steering offset width; -4 is the unused code of this width
    localparam int OFF_W   = 3;
    localparam int ENTRY_W = OFF_W + 1;

    typedef struct packed {
        logic             bypass;
        logic [OFF_W-1:0] offset;
    } entry_t;

endpackage

// File: rtl/psteer_cfg_bank.sv
module psteer_cfg_bank
    import psteer_pkg::*;
#(
    parameter  int NUM_CLUSTERS = 32,
    localparam int AW           = $clog2(NUM_CLUSTERS)
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        we_i,
    input  logic [AW-1:0]               addr_i,
    input  entry_t                      wdata_i,
    output entry_t [NUM_CLUSTERS-1:0]   entries_o
);

    typedef struct packed {
        entry_t [NUM_CLUSTERS-1:0] entries;
    } bank_t;

    bank_t bank_d, bank_q;

    always_comb begin
        bank_d = bank_q;
        for (int i = 0; i < NUM_CLUSTERS; i++) begin
            if (we_i && (addr_i == AW'(i))) begin
                bank_d.entries[i] = wdata_i;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bank_q <= '0;
        end else begin
            bank_q <= bank_d;
        end
    end

    assign entries_o = bank_q.entries;

    for (genvar i = 0; i < NUM_CLUSTERS; i++) begin : g_chk
        assert_entry_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
            (we_i && addr_i == AW'(i)) |=> (bank_q.entries[i] == $past(wdata_i)));
        assert_entry_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
            !(we_i && addr_i == AW'(i)) |=> $stable(bank_q.entries[i]));
    end

endmodule

// File: rtl/psteer_cluster_or.sv
module psteer_cluster_or #(
    parameter int NUM_CLUSTERS = 32,
    parameter int TERMS        = 5
) (
    input  logic [NUM_CLUSTERS*TERMS-1:0] terms_i,
    output logic [NUM_CLUSTERS-1:0]       sum_o
);

    for (genvar j = 0; j < NUM_CLUSTERS; j++) begin : g_cluster
        assign sum_o[j] = |terms_i[j*TERMS +: TERMS];
    end

endmodule

// File: rtl/psteer_route.sv
module psteer_route
    import psteer_pkg::*;
#(
    parameter  int NUM_CLUSTERS = 32,
    parameter  int MAX_REACH    = 3,
    localparam int SPAN         = 2 * MAX_REACH + 1
) (
    input  logic   [NUM_CLUSTERS-1:0] cluster_or_i,
    input  entry_t [NUM_CLUSTERS-1:0] entries_i,
    output logic   [NUM_CLUSTERS-1:0] data_o
);

    logic [NUM_CLUSTERS-1:0][SPAN-1:0] hit;

    for (genvar k = 0; k < NUM_CLUSTERS; k++) begin : g_out
        for (genvar d = 0; d < SPAN; d++) begin : g_dist
            localparam int               OFF  = d - MAX_REACH;
            localparam int               SRC  = k - OFF;
            localparam logic [OFF_W-1:0] CODE = OFF_W'(OFF);
            if (SRC >= 0 && SRC < NUM_CLUSTERS) begin : g_src
                assign hit[k][d] = cluster_or_i[SRC]
                                 && !entries_i[SRC].bypass
                                 && (entries_i[SRC].offset == CODE);
            end else begin : g_edge
                assign hit[k][d] = 1'b0;
            end
        end
        assign data_o[k] = entries_i[k].bypass ? cluster_or_i[k] : (|hit[k]);
    end

endmodule

// File: rtl/psteer_top.sv
module psteer_top
    import psteer_pkg::*;
#(
    parameter  int NUM_CLUSTERS = 32,
    parameter  int TERMS        = 5,
    parameter  int CTRL_TERMS   = 5,
    parameter  int MAX_REACH    = 3,
    localparam int AW           = $clog2(NUM_CLUSTERS)
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          cfg_we_i,
    input  logic [AW-1:0]                 cfg_addr_i,
    input  logic [ENTRY_W-1:0]            cfg_wdata_i,
    input  logic [NUM_CLUSTERS*TERMS-1:0] pterm_i,
    input  logic [CTRL_TERMS-1:0]         ctrl_term_i,
    output logic [NUM_CLUSTERS-1:0]       mc_data_o,
    output logic [CTRL_TERMS-1:0]         ctrl_o
);

    entry_t [NUM_CLUSTERS-1:0] entries;
    logic   [NUM_CLUSTERS-1:0] cluster_or;

    psteer_cfg_bank #(
        .NUM_CLUSTERS (NUM_CLUSTERS)
    ) bank_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .we_i      (cfg_we_i),
        .addr_i    (cfg_addr_i),
        .wdata_i   (entry_t'(cfg_wdata_i)),
        .entries_o (entries)
    );

    psteer_cluster_or #(
        .NUM_CLUSTERS (NUM_CLUSTERS),
        .TERMS        (TERMS)
    ) reduce_i (
        .terms_i (pterm_i),
        .sum_o   (cluster_or)
    );

    psteer_route #(
        .NUM_CLUSTERS (NUM_CLUSTERS),
        .MAX_REACH    (MAX_REACH)
    ) route_i (
        .cluster_or_i (cluster_or),
        .entries_i    (entries),
        .data_o       (mc_data_o)
    );

    // Control terms bypass all steering
    assign ctrl_o = ctrl_term_i;

    assert_single_use_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(mc_data_o) <= $countones(cluster_or));

    assert_quiet_out_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (cluster_or == '0) |-> (mc_data_o == '0));

    for (genvar k = 0; k < NUM_CLUSTERS; k++) begin : g_bypass_chk
        assert_bypass_own_R7: assert property (@(posedge clk) disable iff (!rst_n)
            entries[k].bypass |-> (mc_data_o[k] == cluster_or[k]));
    end

endmodule

// File: tb/psteer_top_tb_top.sv
module psteer_top_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int NC = 32;
    localparam int T  = 5;
    localparam int CT = 5;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cfg_we = 1'b0;
    logic [4:0]    cfg_addr = '0;
    logic [3:0]    cfg_wdata = '0;
    logic [NC*T-1:0] pterm = '0;
    logic [CT-1:0] ctrl_term = '0;
    logic [NC-1:0] mc_data;
    logic [CT-1:0] ctrl_out;

    int checks = 0;
    int errors = 0;
    logic [3:0] model [NC];

    always #(CLK_PERIOD/2) clk = ~clk;

    psteer_top dut_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .cfg_we_i    (cfg_we),
        .cfg_addr_i  (cfg_addr),
        .cfg_wdata_i (cfg_wdata),
        .pterm_i     (pterm),
        .ctrl_term_i (ctrl_term),
        .mc_data_o   (mc_data),
        .ctrl_o      (ctrl_out)
    );

    typedef struct packed {
        logic [4:0] addr;
        logic [3:0] data;
        logic [4:0] src;
        logic       hit;
        logic [4:0] idx;
    } vec_t;

    // One write after reset, one cluster driven, expected target output
    localparam vec_t VEC [10] = '{
        '{5'd0,  4'b0011, 5'd0,  1'b1, 5'd3 },
        '{5'd0,  4'b0111, 5'd0,  1'b0, 5'd0 },
        '{5'd31, 4'b0001, 5'd31, 1'b0, 5'd0 },
        '{5'd31, 4'b0101, 5'd31, 1'b1, 5'd28},
        '{5'd10, 4'b0110, 5'd10, 1'b1, 5'd8 },
        '{5'd10, 4'b0100, 5'd10, 1'b0, 5'd0 },
        '{5'd5,  4'b1010, 5'd5,  1'b1, 5'd5 },
        '{5'd16, 4'b0000, 5'd16, 1'b1, 5'd16},
        '{5'd29, 4'b0010, 5'd29, 1'b1, 5'd31},
        '{5'd2,  4'b0110, 5'd2,  1'b1, 5'd0 }
    };

    function automatic logic [NC-1:0] ref_out(input logic [NC*T-1:0] pt);
        logic [NC-1:0] r;
        logic [NC-1:0] cor;
        r = '0;
        for (int j = 0; j < NC; j++) cor[j] = |pt[j*T +: T];
        for (int j = 0; j < NC; j++) begin
            int o;
            int t;
            o = int'($signed(model[j][2:0]));
            t = j + o;
            if (!model[j][3] && o != -4 && t >= 0 && t < NC) r[t] = r[t] | cor[j];
        end
        for (int k = 0; k < NC; k++) if (model[k][3]) r[k] = cor[k];
        return r;
    endfunction

    function automatic logic [NC*T-1:0] rand_terms();
        logic [NC*T-1:0] v;
        for (int w = 0; w < T; w++) v[w*32 +: 32] = $urandom() & $urandom() & $urandom();
        return v;
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic do_reset();
        cfg_we = 1'b0;
        rst_n  = 1'b0;
        @(negedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        for (int j = 0; j < NC; j++) model[j] = 4'b0000;
    endtask

    task automatic cfg_write(input logic [4:0] a, input logic [3:0] d);
        @(negedge clk);
        cfg_we    = 1'b1;
        cfg_addr  = a;
        cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
        model[a] = d;
    endtask

    task automatic drive_one(input int cl, input int term);
        pterm = '0;
        pterm[cl*T + term] = 1'b1;
        #1;
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        checks++;
        errors++;
        $display("FAIL watchdog actual timeout expected completion");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        // R3 / R1: reset state, each output carries its own cluster OR
        do_reset();
        for (int n = 0; n < 3; n++) begin
            pterm = rand_terms();
            #1;
            chk("R3 reset own-cluster", mc_data, ref_out(pterm));
        end
        drive_one(7, 4);
        chk("R1 single term reaches own output", mc_data, 32'h1 << 7);
        // R9: control terms pass through
        ctrl_term = 5'b10110;
        #1;
        chk("R9 control passthrough", 32'(ctrl_out), 32'(5'b10110));

        // R4 / R5 / R7 table walk
        for (int i = 0; i < 10; i++) begin
            do_reset();
            cfg_write(VEC[i].addr, VEC[i].data);
            drive_one(int'(VEC[i].src), i % T);
            chk($sformatf("R4 R5 R7 vector %0d", i), mc_data,
                VEC[i].hit ? (32'h1 << VEC[i].idx) : 32'h0);
        end

        // R6: seven clusters merged into output 10
        do_reset();
        cfg_write(5'd7,  4'b0011);
        cfg_write(5'd8,  4'b0010);
        cfg_write(5'd9,  4'b0001);
        cfg_write(5'd10, 4'b0000);
        cfg_write(5'd11, 4'b0111);
        cfg_write(5'd12, 4'b0110);
        cfg_write(5'd13, 4'b0101);
        drive_one(7, 4);
        chk("R6 far-left cluster merged", mc_data, 32'h1 << 10);
        drive_one(13, 0);
        chk("R6 far-right cluster merged", mc_data, 32'h1 << 10);
        pterm = '0;
        pterm[7*T +: 35] = '1;
        #1;
        chk("R6 R8 all 35 terms into one output", mc_data, 32'h1 << 10);
        pterm = '0;
        #1;
        chk("R6 no contributors gives zero", mc_data, 32'h0);
        ctrl_term = 5'b01001;
        #1;
        chk("R9 control unaffected by steering", 32'(ctrl_out), 32'(5'b01001));

        // R10: strobe low, address/data toggled
        @(negedge clk);
        cfg_addr  = 5'd10;
        cfg_wdata = 4'b1000;
        @(negedge clk);
        cfg_addr  = 5'd7;
        cfg_wdata = 4'b0000;
        @(negedge clk);
        drive_one(7, 2);
        chk("R10 no write without strobe", mc_data, 32'h1 << 10);

        // R7: bypass on output 10
        cfg_write(5'd10, 4'b1000);
        drive_one(7, 2);
        chk("R7 steered cluster ignored by bypassed output", mc_data, 32'h0);
        drive_one(10, 1);
        chk("R7 bypassed output takes own cluster", mc_data, 32'h1 << 10);
        drive_one(11, 3);
        chk("R7 R2 other steered cluster also ignored", mc_data, 32'h0);

        // R2 / R6 / R8: randomized configurations against the model
        for (int it = 0; it < 40; it++) begin
            for (int j = 0; j < NC; j++) begin
                logic [3:0] d;
                d = 4'($urandom_range(0, 15));
                if ($urandom_range(0, 3) != 0) d[3] = 1'b0;
                cfg_write(5'(j), d);
            end
            for (int n = 0; n < 3; n++) begin
                pterm = rand_terms();
                #1;
                chk($sformatf("R2 R6 R8 random config %0d", it), mc_data, ref_out(pterm));
            end
        end

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule